// File: doc/BRIEF.md
# Nonvolatile Shadowed Dual State Latch

This block is a small edge-triggered register whose every captured state is mirrored into a retained shadow store. Contents of the shadow store survive a loss of supply. When the supply returns and the block is enabled, the stored value is put back on the outputs without software help. The block runs on a fast internal sample clock. A slow user clock, a group of data inputs, an active-high enable and a supply-good indication are oversampled against that clock. The outputs carry per-bit output-enable flags, which stand in for a tri-state driver.

A five-state controller sequences the block:

- `S_WAIT_EN`: powered but disabled. This is the state after supply-good rises.
- `S_RESTORE`: the timed read-back of the shadow store. Outputs are still released.
- `S_LOCKOUT`: outputs are driven with the restored value, and user clock edges are discarded.
- `S_RUN`: normal capture.
- `S_PARK`: enable dropped after normal running. Outputs are released, and the live value is kept.

The transitions are:

- `S_WAIT_EN` goes to `S_RESTORE` when enable is high.
- `S_RESTORE` goes to `S_LOCKOUT` when its timer completes, or to `S_WAIT_EN` if enable drops.
- `S_LOCKOUT` goes to `S_RUN` when its timer completes, or to `S_WAIT_EN` if enable drops.
- `S_RUN` goes to `S_PARK` when enable drops.
- `S_PARK` goes to `S_RUN` when enable returns.

Supply-good low forces `S_WAIT_EN` from any state.

Top module: `nv_state_keeper`

## Requirements
- R1: In `S_RUN` with `en` high, a rising edge of `user_clk` (seen after the SYNC_STAGES-flop synchroniser) loads `din` into `q`. Bit i of `din` goes to bit i of `q`.
- R2: While `user_clk` stays high or stays low, `q` does not change, whatever `din` does.
- R3: One sample-clock cycle after `en` is seen low, `q_oe` is all zeros. While `en` is low, `user_clk` and `din` have no effect on `q` or on the shadow store.
- R4: The shadow store is written only when a capture changes the held value. Each such write raises `wr_busy` for exactly one sample-clock cycle. A capture of an equal value raises no pulse.
- R5: After supply-good, once `en` is high, `q_oe` stays all zeros for RESTORE_CYC cycles. The outputs are then driven (all ones) and `q` equals the shadow store contents.
- R6: For LOCKOUT_CYC cycles after the restore completes, user clock edges are ignored and `q` keeps the restored value.
- R7: With `en` held high throughout, a rise of `pwr_ok` alone starts the restore sequence of R5.
- R8: While `pwr_ok` is low, `q_oe` is all zeros, `wr_busy` is low and `q` is cleared to zero. The shadow store keeps its contents.
- R9: When `en` returns high in `S_PARK`, the outputs are driven again on the next cycle with the previously held value, without a restore delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sample clock |
| pwr_ok | input | 1 | Supply-good; low acts as asynchronous reset of all volatile state |
| user_clk | input | 1 | Slow user clock, asynchronous to `clk` |
| en | input | 1 | Active-high enable |
| din | input | WIDTH | Data inputs |
| q | output | WIDTH | Held state |
| q_oe | output | WIDTH | Per-bit output drive enable (0 = high impedance) |
| wr_busy | output | 1 | One-cycle pulse on each shadow store write |

## Verification
The bench builds the block with WIDTH=2, RESTORE_CYC=4 and LOCKOUT_CYC=12. With these values, all sixteen held-to-next value pairs can be swept, so both the write pulse and its absence are observed for every transition. The short timers put both ends of the restore window and the whole lockout window within a few dozen cycles. Two power cycles are exercised, one with enable toggled and one with enable tied high. Together they show the store surviving, and show that an update ignored while disabled never reaches the store.

// File: rtl/nvk_pkg.sv
package nvk_pkg;
    typedef enum logic [2:0] {
        S_WAIT_EN  = 3'd0,
        S_RESTORE  = 3'd1,
        S_LOCKOUT  = 3'd2,
        S_RUN      = 3'd3,
        S_PARK     = 3'd4
    } nvk_state_e;
endpackage

// File: rtl/nvk_edge_sync.sv
// Multi-flop synchroniser followed by a rising-edge detector.
module nvk_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= async_in;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], async_in};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/nvk_cycle_timer.sv
// Counts while run is high; done marks the last of CYCLES cycles.
module nvk_cycle_timer #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (!run)         cnt <= '0;
        else if (cnt != LAST)  cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == LAST);
endmodule

// File: rtl/nvk_shadow_store.sv
// Retained cells: unaffected by the supply-good reset.
module nvk_shadow_store #(
    parameter int              WIDTH = 2,
    parameter logic [WIDTH-1:0] INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] data,
    output logic             busy
);
    logic [WIDTH-1:0] cells = INIT;

    always_ff @(posedge clk) begin
        if (wr_en) cells <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy <= 1'b0;
        else        busy <= wr_en;
    end

    assign data = cells;
endmodule

// File: rtl/nv_state_keeper.sv
module nv_state_keeper
    import nvk_pkg::*;
#(
    parameter int               WIDTH       = 2,
    parameter int               SYNC_STAGES = 2,
    parameter int               RESTORE_CYC = 32,
    parameter int               LOCKOUT_CYC = 256,
    parameter logic [WIDTH-1:0] INIT_STATE  = '0
) (
    input  logic             clk,
    input  logic             pwr_ok,
    input  logic             user_clk,
    input  logic             en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] q_oe,
    output logic             wr_busy
);
    nvk_state_e       state, nxt;
    logic [WIDTH-1:0] cur;
    logic [WIDTH-1:0] stored;
    logic             edge_rise;
    logic             restore_done;
    logic             lock_done;
    logic             capture;
    logic             changed;

    nvk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (pwr_ok),
        .async_in (user_clk),
        .rise     (edge_rise)
    );

    nvk_cycle_timer #(.CYCLES(RESTORE_CYC)) u_restore_tmr (
        .clk   (clk),
        .rst_n (pwr_ok),
        .run   (state == S_RESTORE),
        .done  (restore_done)
    );

    nvk_cycle_timer #(.CYCLES(LOCKOUT_CYC)) u_lock_tmr (
        .clk   (clk),
        .rst_n (pwr_ok),
        .run   (state == S_LOCKOUT),
        .done  (lock_done)
    );

    assign capture = (state == S_RUN) && en && edge_rise;
    assign changed = capture && (din != cur);

    nvk_shadow_store #(.WIDTH(WIDTH), .INIT(INIT_STATE)) u_store (
        .clk     (clk),
        .rst_n   (pwr_ok),
        .wr_en   (changed),
        .wr_data (din),
        .data    (stored),
        .busy    (wr_busy)
    );

    // State register
    always_ff @(posedge clk or negedge pwr_ok) begin
        if (!pwr_ok) state <= S_WAIT_EN;
        else         state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_WAIT_EN: if (en) nxt = S_RESTORE;
            S_RESTORE: begin
                if (!en)               nxt = S_WAIT_EN;
                else if (restore_done) nxt = S_LOCKOUT;
            end
            S_LOCKOUT: begin
                if (!en)            nxt = S_WAIT_EN;
                else if (lock_done) nxt = S_RUN;
            end
            S_RUN:  if (!en) nxt = S_PARK;
            S_PARK: if (en)  nxt = S_RUN;
            default: nxt = S_WAIT_EN;
        endcase
    end

    // Held value: loaded from the store at restore, from din at capture
    always_ff @(posedge clk or negedge pwr_ok) begin
        if (!pwr_ok)                                  cur <= '0;
        else if (state == S_RESTORE && restore_done && en) cur <= stored;
        else if (capture)                             cur <= din;
    end

    // Output process
    always_comb begin
        q = cur;
        unique case (state)
            S_LOCKOUT, S_RUN: q_oe = '1;
            default:          q_oe = '0;
        endcase
    end
endmodule

// File: rtl/nv_state_keeper_chk.sv
module nv_state_keeper_chk #(
    parameter int WIDTH = 2
) (
    input logic             clk,
    input logic             pwr_ok,
    input logic             en,
    input logic [WIDTH-1:0] q,
    input logic [WIDTH-1:0] q_oe,
    input logic             wr_busy,
    input logic             edge_rise,
    input logic [WIDTH-1:0] stored
);
    // R3
    en_low_release_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
        !en |=> (q_oe == '0));

    // R4
    busy_on_change_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
        wr_busy |-> (q != $past(q)));

    // R4
    change_sets_busy_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
        ((q_oe == '1) && ($past(q_oe) == '1) && (q != $past(q))) |-> wr_busy);

    // R2
    hold_without_edge_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
        ((q != $past(q)) && ($past(q_oe) == '1)) |-> $past(edge_rise));

    // R5
    restore_value_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
        $rose(q_oe[0]) |-> (q == stored));

    // R8
    always @(posedge clk) begin
        if (!pwr_ok) begin
            pwr_low_idle_chk: assert (q_oe == '0 && !wr_busy && q == '0);
        end
    end
endmodule

bind nv_state_keeper nv_state_keeper_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .pwr_ok    (pwr_ok),
    .en        (en),
    .q         (q),
    .q_oe      (q_oe),
    .wr_busy   (wr_busy),
    .edge_rise (edge_rise),
    .stored    (stored)
);

// File: tb/nv_state_keeper_bench.sv
module nv_state_keeper_bench;
    localparam int W = 2;

    logic         clk = 1'b0;
    logic         pwr_ok = 1'b0;
    logic         user_clk = 1'b0;
    logic         en = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] q;
    logic [W-1:0] q_oe;
    logic         wr_busy;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    nv_state_keeper #(
        .WIDTH(W), .SYNC_STAGES(2), .RESTORE_CYC(4), .LOCKOUT_CYC(12), .INIT_STATE('0)
    ) u_nv_state_keeper (
        .clk(clk), .pwr_ok(pwr_ok), .user_clk(user_clk), .en(en),
        .din(din), .q(q), .q_oe(q_oe), .wr_busy(wr_busy)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One user clock pulse; returns number of busy cycles seen.
    task automatic pulse(input logic [W-1:0] d, output int busy_cnt);
        busy_cnt = 0;
        din = d;
        user_clk = 1'b1;
        for (int i = 0; i < 4; i++) begin tick(1); busy_cnt += wr_busy; end
        user_clk = 1'b0;
        for (int i = 0; i < 4; i++) begin tick(1); busy_cnt += wr_busy; end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int bc;
        tick(3);
        check("R8 reset oe", q_oe, 0);
        check("R8 reset busy", wr_busy, 0);
        check("R8 reset q", q, 0);

        pwr_ok = 1'b1;
        tick(2);
        check("R3 powered en low oe", q_oe, 0);

        en = 1'b1;
        tick(2);
        check("R5 restore pending oe", q_oe, 0);
        tick(6);
        check("R5 restored oe", q_oe, 3);
        check("R5 restored q", q, 0);

        // R6: edge inside lockout window ignored
        pulse(2'd3, bc);
        check("R6 lockout q", q, 0);
        check("R6 lockout busy", bc, 0);
        tick(4);

        // R1 / R4 sweep over every held-to-next pair
        for (int f = 0; f < 4; f++) begin
            for (int t = 0; t < 4; t++) begin
                pulse(W'(f), bc);
                pulse(W'(t), bc);
                check("R1 capture q", q, t);
                check("R4 busy count", bc, (t != f) ? 1 : 0);
            end
        end

        // R2: steady high user clock, toggling data
        pulse(2'd1, bc);
        user_clk = 1'b1;
        tick(6);
        bc = 0;
        for (int k = 0; k < 4; k++) begin
            din = W'(k);
            for (int i = 0; i < 5; i++) begin tick(1); bc += wr_busy; end
        end
        check("R2 steady high q", q, 1);
        check("R2 steady high busy", bc, 0);
        user_clk = 1'b0;
        for (int k = 0; k < 4; k++) begin din = W'(3 - k); tick(5); end
        check("R2 steady low q", q, 1);

        // R3 / R9
        pulse(2'd2, bc);
        en = 1'b0;
        tick(1);
        check("R3 en low oe", q_oe, 0);
        pulse(2'd1, bc);
        check("R3 ignored busy", bc, 0);
        en = 1'b1;
        tick(1);
        check("R9 reenable oe", q_oe, 3);
        check("R9 reenable q", q, 2);

        // R8 / R7: power cycle with en tied high
        pwr_ok = 1'b0;
        tick(3);
        check("R8 off oe", q_oe, 0);
        check("R8 off q", q, 0);
        check("R8 off busy", wr_busy, 0);
        pwr_ok = 1'b1;
        tick(2);
        check("R7 restore pending oe", q_oe, 0);
        tick(6);
        check("R7 restored oe", q_oe, 3);
        check("R3 store kept value q", q, 2);
        pulse(2'd0, bc);
        check("R6 lockout after cycle q", q, 2);
        tick(12);
        pulse(2'd1, bc);
        check("R1 capture after lockout q", q, 1);
        check("R4 write after lockout busy", bc, 1);

        finish_run();
    end
endmodule